// File: doc/BRIEF.md
# Ready-Triggered SPI Master

This block is a master on a four-wire SPI bus. It moves one 8-bit word per request, shifted MSB first in SPI mode 0. SCLK idles low, the master samples MISO on the rising edge, and MOSI moves on the falling side. A word is started by a level on the `ready_i` request input. The block then frames the word with its active-low slave select. Each part of the frame has a fixed length measured in SPI clock periods, and the gap between words can be stretched by a programmable wait.

All timing comes from one system clock. The SPI period T is four quarter periods, and one quarter lasts 2^`div_sel_i` system clocks. The block counts quarters to place the request-to-select lead, the select-to-first-edge setup, the bit edges, the select release and the acknowledge pulse. The wait that extends the inter-word gap is counted in one of two units, picked by `wait_slow_i`: system clocks, or pulses on `slow_tick_i`, which carries ticks of a slow reference clock (for example 32.768 kHz) already aligned to the system clock.

The transmit word, divider setting, wait length and wait unit are captured when a word starts. A request that arrives while a word or its gap is still running is remembered and served once the block is idle again.

Top module: `spi_rdy_master`

## Requirements
- R1: After reset `ss_no` is high, while `sclk_o`, `mosi_o`, `done_o` and `req_ack_o` are low.
- R2: One quarter lasts 2^`div_sel_i` system clocks and T is four quarters. The 8 SCLK high pulses are spaced by T, so the last falling edge comes 30 quarters after the first rising edge.
- R3: The word goes out on MOSI MSB first, and MOSI changes only while SCLK is low, one quarter after a falling edge. MISO is captured on each rising edge, MSB first, and appears on `rx_word_o`.
- R4: `ss_no` falls 8 quarters (2T) after the clock edge that samples an accepted request. Seen from the cycle in which `ready_i` was raised, that is 8 quarters plus one cycle.
- R5: The first rising SCLK edge comes 8 quarters (2T) after `ss_no` falls, and SCLK is high only while `ss_no` is low.
- R6: `ss_no` rises 4 quarters (T) after the last falling SCLK edge. In that same cycle `done_o` pulses for exactly one cycle and `rx_word_o` takes the new received word. At no other time does `rx_word_o` change.
- R7: `req_ack_o` pulses for one cycle 4 quarters (T) after `ss_no` rises.
- R8: The block accepts no new word until 8 quarters plus the wait length have passed after `ss_no` rises. With the system-clock unit and a pending request, `ss_no` stays high for 16 quarters plus the wait length plus one cycle. A wait length of zero adds nothing.
- R9: With `wait_slow_i` set, the wait counts only cycles in which `slow_tick_i` is high. No further word can start until that many ticks have arrived.
- R10: A request raised while a word or its gap is in progress is held and starts the next word once the block is idle. Any number of such requests during one word yields exactly one further word.
- R11: `tx_word_i`, `div_sel_i`, `wait_len_i` and `wait_slow_i` are captured when a word starts. Changing them during the word has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Word request (data ready), active high |
| tx_word_i | input | WORD_W | Word to transmit |
| div_sel_i | input | DIV_W | Quarter-period exponent: quarter = 2^value system clocks |
| wait_len_i | input | WAIT_W | Extra inter-word wait length |
| wait_slow_i | input | 1 | Wait unit: 0 system clocks, 1 slow ticks |
| slow_tick_i | input | 1 | One-cycle pulse per slow reference tick |
| miso_i | input | 1 | Serial data from slave |
| sclk_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | Serial data to slave |
| ss_no | output | 1 | Slave select, active low |
| rx_word_o | output | WORD_W | Last received word |
| done_o | output | 1 | One-cycle pulse when `rx_word_o` is updated |
| req_ack_o | output | 1 | One-cycle acknowledge of the request, T after select release |

## Verification
The bench builds the block with its default parameters: an 8-bit word, a 3-bit divider exponent and an 8-bit wait length. At run time it selects exponents 0, 1 and 2. This puts quarters of one, two and four clocks within reach, so every interval is checked at more than one scale. The one-clock case is where off-by-one errors in the prescaler show. Wait lengths of zero, five and three slow ticks cover the direct return to idle, the counted system-clock gap and the stalled slow-tick gap.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;

    // Sequencer phases of one framed word
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,   // select high, request seen
        ST_SETUP = 3'd2,   // select low, before first edge
        ST_SHIFT = 3'd3,   // bit edges plus select release delay
        ST_GAP   = 3'd4,   // select high, fixed part of the gap
        ST_WAIT  = 3'd5    // select high, programmable part of the gap
    } seq_state_e;

    // Quarter periods per SPI clock period
    localparam int QPB     = 4;
    // Interval lengths in quarter periods
    localparam int LEAD_Q  = 2 * QPB;
    localparam int SETUP_Q = 2 * QPB;
    localparam int GAP_Q   = 2 * QPB;
    localparam int ACK_Q   = QPB;
    localparam int TAIL_Q  = QPB;

endpackage

// File: rtl/spi_rdy_prescale.sv
module spi_rdy_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             qtick_o
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask    = ~({PRE_W{1'b1}} << div_i);
        qtick_o = run_i && (pre_q == mask);
        if (!run_i || qtick_o) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // With a quarter longer than one clock, ticks never come back to back
    p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qtick_o && div_i != '0 && run_i) |=> !qtick_o);

endmodule

// File: rtl/spi_rdy_shifter.sv
module spi_rdy_shifter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] tx_i,
    input  logic         launch_i,
    input  logic         sample_i,
    input  logic         miso_i,
    input  logic         commit_i,
    output logic         mosi_o,
    output logic [W-1:0] rx_word_o
);
    typedef struct packed {
        logic [W-1:0] tx;
        logic [W-1:0] rx;
        logic [W-1:0] word;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = tx_i;
        end else if (launch_i) begin
            sh_d.tx = {sh_q.tx[W-2:0], 1'b0};
        end
        if (sample_i) begin
            sh_d.rx = {sh_q.rx[W-2:0], miso_i};
        end
        if (commit_i) begin
            sh_d.word = sh_q.rx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi_o    = sh_q.tx[W-1];
    assign rx_word_o = sh_q.word;

    // The received word only moves on a commit
    p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(rx_word_o));

endmodule

// File: rtl/spi_rdy_seq.sv
module spi_rdy_seq
    import spi_rdy_pkg::*;
#(
    parameter int W      = 8,
    parameter int DIV_W  = 3,
    parameter int WAIT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              qtick_i,
    input  logic              slow_tick_i,
    input  logic              slow_sel_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              run_o,
    output logic              ss_no,
    output logic              sclk_o,
    output logic              done_o,
    output logic              ack_o,
    output logic              load_o,
    output logic              launch_o,
    output logic              sample_o,
    output logic              commit_o
);
    localparam int SHIFT_Q = QPB * W + TAIL_Q - 2;
    localparam int MAX_Q   = (SHIFT_Q > LEAD_Q) ? SHIFT_Q : LEAD_Q;
    localparam int QC_W    = $clog2(MAX_Q + 1);

    localparam logic [QC_W-1:0] LEAD_L   = QC_W'(LEAD_Q);
    localparam logic [QC_W-1:0] SETUP_L  = QC_W'(SETUP_Q);
    localparam logic [QC_W-1:0] SHIFT_L  = QC_W'(SHIFT_Q);
    localparam logic [QC_W-1:0] GAP_L    = QC_W'(GAP_Q);
    localparam logic [QC_W-1:0] ACK_L    = QC_W'(ACK_Q);
    localparam logic [QC_W-1:0] EDGES_L  = QC_W'(QPB * W);
    localparam logic [QC_W-1:0] LAUNCH_L = QC_W'(QPB * W - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [QC_W-1:0]   qc;
        logic [WAIT_W-1:0] wcnt;
        logic [WAIT_W-1:0] wlim;
        logic [DIV_W-1:0]  div;
        logic              slow;
        logic              pend;
        logic              ss_n;
        logic              sclk;
        logic              done;
        logic              ack;
    } seq_t;

    seq_t q, d;
    logic [QC_W-1:0] qn;
    logic            unit_tick;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.ack     = 1'b0;
        load_o    = 1'b0;
        launch_o  = 1'b0;
        sample_o  = 1'b0;
        commit_o  = 1'b0;
        qn        = q.qc + 1'b1;
        unit_tick = q.slow ? slow_tick_i : 1'b1;

        if (req_i && q.st != ST_IDLE) begin
            d.pend = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (req_i || q.pend) begin
                    d.st   = ST_LEAD;
                    d.qc   = '0;
                    d.pend = 1'b0;
                    d.div  = div_i;
                    d.wlim = wait_i;
                    d.slow = slow_sel_i;
                    load_o = 1'b1;
                end
            end
            ST_LEAD: begin
                if (qtick_i) begin
                    if (qn == LEAD_L) begin
                        d.st   = ST_SETUP;
                        d.qc   = '0;
                        d.ss_n = 1'b0;
                    end else begin
                        d.qc = qn;
                    end
                end
            end
            ST_SETUP: begin
                if (qtick_i) begin
                    if (qn == SETUP_L) begin
                        d.st     = ST_SHIFT;
                        d.qc     = '0;
                        d.sclk   = 1'b1;
                        sample_o = 1'b1;
                    end else begin
                        d.qc = qn;
                    end
                end
            end
            ST_SHIFT: begin
                if (qtick_i) begin
                    d.qc = qn;
                    if (qn == SHIFT_L) begin
                        d.st     = ST_GAP;
                        d.qc     = '0;
                        d.ss_n   = 1'b1;
                        d.done   = 1'b1;
                        commit_o = 1'b1;
                    end else if (qn < EDGES_L) begin
                        unique case (qn[1:0])
                            2'd0: begin
                                d.sclk   = 1'b1;
                                sample_o = 1'b1;
                            end
                            2'd2: d.sclk = 1'b0;
                            2'd3: launch_o = (qn < LAUNCH_L);
                            default: ;
                        endcase
                    end
                end
            end
            ST_GAP: begin
                if (qtick_i) begin
                    d.qc = qn;
                    if (qn == ACK_L) begin
                        d.ack = 1'b1;
                    end
                    if (qn == GAP_L) begin
                        d.qc   = '0;
                        d.wcnt = '0;
                        d.st   = (q.wlim == '0) ? ST_IDLE : ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (unit_tick) begin
                    if (q.wcnt == q.wlim - 1'b1) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ss_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign div_o  = q.div;
    assign run_o  = (q.st == ST_LEAD) || (q.st == ST_SETUP) ||
                    (q.st == ST_SHIFT) || (q.st == ST_GAP);
    assign ss_no  = q.ss_n;
    assign sclk_o = q.sclk;
    assign done_o = q.done;
    assign ack_o  = q.ack;

    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE) |-> (q.ss_n && !q.sclk));

    p_sclk_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.sclk |-> !q.ss_n);

    p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> !q.done);

    p_done_at_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> (q.ss_n && !$past(q.ss_n)));

    p_ack_select_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.ack |-> q.ss_n);

    p_wait_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_WAIT) |-> (q.wlim != '0));

    p_div_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && $past(run_o)) |-> $stable(q.div));

endmodule

// File: rtl/spi_rdy_master.sv
module spi_rdy_master #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 3,
    parameter int WAIT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ready_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic [WAIT_W-1:0] wait_len_i,
    input  logic              wait_slow_i,
    input  logic              slow_tick_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              ss_no,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              done_o,
    output logic              req_ack_o
);
    logic [DIV_W-1:0] div_run;
    logic             run, qtick;
    logic             load, launch, sample, commit;

    spi_rdy_prescale #(.DIV_W(DIV_W)) prescale_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .div_i   (div_run),
        .qtick_o (qtick)
    );

    spi_rdy_seq #(.W(WORD_W), .DIV_W(DIV_W), .WAIT_W(WAIT_W)) seq_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (ready_i),
        .qtick_i     (qtick),
        .slow_tick_i (slow_tick_i),
        .slow_sel_i  (wait_slow_i),
        .div_i       (div_sel_i),
        .wait_i      (wait_len_i),
        .div_o       (div_run),
        .run_o       (run),
        .ss_no       (ss_no),
        .sclk_o      (sclk_o),
        .done_o      (done_o),
        .ack_o       (req_ack_o),
        .load_o      (load),
        .launch_o    (launch),
        .sample_o    (sample),
        .commit_o    (commit)
    );

    spi_rdy_shifter #(.W(WORD_W)) shifter_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load),
        .tx_i      (tx_word_i),
        .launch_i  (launch),
        .sample_i  (sample),
        .miso_i    (miso_i),
        .commit_i  (commit),
        .mosi_o    (mosi_o),
        .rx_word_o (rx_word_o)
    );

    // MOSI never moves while SCLK stays high
    p_mosi_steady_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: tb/spi_rdy_master_tb_top.sv
module spi_rdy_master_tb_top;
    localparam int W = 8;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         ready_i = 1'b0;
    logic [W-1:0] tx_word_i = '0;
    logic [2:0]   div_sel_i = '0;
    logic [7:0]   wait_len_i = '0;
    logic         wait_slow_i = 1'b0;
    logic         slow_tick_i = 1'b0;
    logic         miso_i = 1'b0;
    logic         sclk_o, mosi_o, ss_no, done_o, req_ack_o;
    logic [W-1:0] rx_word_o;

    always #5 clk_i = ~clk_i;

    spi_rdy_master dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .tx_word_i(tx_word_i),
        .div_sel_i(div_sel_i), .wait_len_i(wait_len_i), .wait_slow_i(wait_slow_i),
        .slow_tick_i(slow_tick_i), .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .ss_no(ss_no), .rx_word_o(rx_word_o), .done_o(done_o), .req_ack_o(req_ack_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always @(posedge clk_i) cyc <= cyc + 1;

    // Monitor and slave model (sampled away from the active edge)
    logic [W-1:0] slave_word = '0;
    logic [W-1:0] slave_sh = '0;
    logic [W-1:0] mosi_cap = '0;
    logic [W-1:0] rx_seen = '0;
    logic ss_prev = 1'b1, sclk_prev = 1'b0, done_prev = 1'b0;
    int t_ss_fall = 0, t_ss_rise = 0, t_first_rise = 0, t_last_fall = 0;
    int t_ack = 0, t_done = 0, hi_w = 0;
    int n_rise = 0, n_frames = 0, n_done = 0, n_ack = 0, done_long = 0;

    always @(negedge clk_i) begin
        if (rst_ni) begin
            if (ss_prev && !ss_no) begin
                t_ss_fall = cyc;
                hi_w      = cyc - t_ss_rise;
                n_frames++;
                n_rise    = 0;
                mosi_cap  = '0;
                miso_i    = slave_word[W-1];
                slave_sh  = slave_word << 1;
            end
            if (!ss_prev && ss_no) t_ss_rise = cyc;
            if (!sclk_prev && sclk_o) begin
                if (n_rise == 0) t_first_rise = cyc;
                n_rise++;
                mosi_cap = {mosi_cap[W-2:0], mosi_o};
            end
            if (sclk_prev && !sclk_o) begin
                t_last_fall = cyc;
                miso_i      = slave_sh[W-1];
                slave_sh    = slave_sh << 1;
            end
            if (req_ack_o) begin
                t_ack = cyc;
                n_ack++;
            end
            if (done_o) begin
                if (done_prev) done_long++;
                else begin
                    t_done  = cyc;
                    rx_seen = rx_word_o;
                    n_done++;
                end
            end
            ss_prev   = ss_no;
            sclk_prev = sclk_o;
            done_prev = done_o;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_ready(output int t_req);
        @(negedge clk_i);
        ready_i = 1'b1;
        t_req   = cyc;
        @(negedge clk_i);
        ready_i = 1'b0;
    endtask

    task automatic wait_for_done(input int target);
        while (n_done < target) @(negedge clk_i);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    // Frame timing and data of the most recent word
    task automatic check_frame(input int q, input int t_req, input logic [W-1:0] tx,
                               input logic [W-1:0] slv);
        check("R4 request to select low", t_ss_fall - t_req, 8*q + 1);
        check("R5 select low to first rise", t_first_rise - t_ss_fall, 8*q);
        check("R2 first rise to last fall", t_last_fall - t_first_rise, 30*q);
        check("R2 rising edge count", n_rise, W);
        check("R6 last fall to select high", t_ss_rise - t_last_fall, 4*q);
        check("R6 done with select high", t_done, t_ss_rise);
        check("R6 done single cycle", done_long, 0);
        check("R3 mosi word", int'(mosi_cap), int'(tx));
        check("R3 received word", int'(rx_seen), int'(slv));
        check("R7 ack after select high", t_ack - t_ss_rise, 4*q);
    endtask

    task automatic t_reset;
        check("R1 select idle high", int'(ss_no), 1);
        check("R1 sclk low", int'(sclk_o), 0);
        check("R1 mosi low", int'(mosi_o), 0);
        check("R1 done low", int'(done_o), 0);
        check("R1 ack low", int'(req_ack_o), 0);
    endtask

    task automatic t_single(input int div, input logic [W-1:0] tx, input logic [W-1:0] slv);
        int t_req, d0, a0;
        @(negedge clk_i);
        div_sel_i   = 3'(div);
        tx_word_i   = tx;
        slave_word  = slv;
        wait_len_i  = '0;
        wait_slow_i = 1'b0;
        d0 = n_done;
        a0 = n_ack;
        pulse_ready(t_req);
        wait_for_done(d0 + 1);
        while (n_ack <= a0) @(negedge clk_i);
        check_frame(1 << div, t_req, tx, slv);
        idle_cycles(20);
    endtask

    // R11: inputs changed mid-word do not affect it
    task automatic t_latch;
        int t_req, d0, a0;
        @(negedge clk_i);
        div_sel_i  = 3'd1;
        tx_word_i  = 8'hC3;
        slave_word = 8'h5A;
        wait_len_i = '0;
        d0 = n_done;
        a0 = n_ack;
        pulse_ready(t_req);
        idle_cycles(3);
        tx_word_i  = 8'h00;
        div_sel_i  = 3'd3;
        wait_len_i = 8'd40;
        wait_for_done(d0 + 1);
        while (n_ack <= a0) @(negedge clk_i);
        check_frame(2, t_req, 8'hC3, 8'h5A);
        idle_cycles(20);
        check("R11 no wait taken from late value", int'(ss_no), 1);
    endtask

    // R8 and R10: held requests and the programmed gap in system clocks
    task automatic t_back_to_back(input int div, input int wlen);
        int t_req, d0, f0, q;
        q = 1 << div;
        @(negedge clk_i);
        div_sel_i   = 3'(div);
        wait_len_i  = 8'(wlen);
        wait_slow_i = 1'b0;
        tx_word_i   = 8'h96;
        slave_word  = 8'h69;
        d0 = n_done;
        f0 = n_frames;
        pulse_ready(t_req);
        idle_cycles(20);
        pulse_ready(t_req);
        idle_cycles(10);
        pulse_ready(t_req);
        wait_for_done(d0 + 2);
        check("R8 select high width", hi_w, 16*q + wlen + 1);
        check("R3 second word mosi", int'(mosi_cap), 8'h96);
        idle_cycles(300);
        check("R10 held requests give one word", n_frames - f0, 2);
    endtask

    // R9: wait counted in slow ticks
    task automatic t_slow_wait;
        int t_req, d0, f0, y;
        @(negedge clk_i);
        div_sel_i   = 3'd0;
        wait_len_i  = 8'd3;
        wait_slow_i = 1'b1;
        tx_word_i   = 8'h3C;
        slave_word  = 8'hA5;
        d0 = n_done;
        f0 = n_frames;
        pulse_ready(t_req);
        idle_cycles(15);
        pulse_ready(t_req);
        wait_for_done(d0 + 1);
        idle_cycles(300);
        check("R9 stalled without slow ticks", n_frames - f0, 1);
        y = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_i);
            slow_tick_i = 1'b1;
            y = cyc;
            @(negedge clk_i);
            slow_tick_i = 1'b0;
            idle_cycles(3);
        end
        while (n_frames < f0 + 2) @(negedge clk_i);
        check("R9 start after last slow tick", t_ss_fall - y, 8 + 2);
        wait_for_done(d0 + 2);
        check("R3 word after slow wait", int'(rx_seen), 8'hA5);
    endtask

    initial begin
        repeat (5) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        idle_cycles(3);
        t_reset();
        t_single(1, 8'hA5, 8'h3C);
        t_single(0, 8'h01, 8'h80);
        t_single(2, 8'h6B, 8'hD4);
        t_single(0, 8'hFF, 8'h00);
        t_latch();
        t_back_to_back(1, 5);
        t_back_to_back(0, 0);
        t_slow_wait();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule